// File: doc/BRIEF.md
# Masked Interrupt Request Controller

This block gathers up to eight device interrupt requests into a pending register and drives one level interrupt line to the host. Devices set pending bits through a post vector and remove them through a clear vector. Software controls which lines reach the host by writing a mask, and it retires a serviced request by writing the request's index to an acknowledge port. The host line is high whenever some pending bit is also enabled.

The mask is kept internally as an enable vector, the complement of what software writes, so a 1 written to the mask disables its line. Mask reads return the value as written. A second, cascaded controller is only present as a stub. Its mask is stored and read back in the same inverted way, but it never affects the interrupt. Its status port reads zero, and writes to its acknowledge port are accepted and dropped.

The register port has one address, a write strobe and an 8-bit write byte. Reads are combinational and return a 64-bit word in which every byte-wide register is zero-extended.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the pending register is zero, both mask ports read 0xFF, the cascaded status reads 0x00 and irq_out is low.
- R2: A write to address 0 (primary mask) stores the complement of the data as the enable vector. Reading address 0 returns the byte as written.
- R3: irq_out is high exactly when the pending AND enable vectors are nonzero. It follows a mask write, post, clear or acknowledge in the cycle after the clock edge that registers the change.
- R4: A write to address 4 (primary acknowledge) clears the pending bit whose index is in data bits 3:0. Data bits 7:4 are ignored, and indices 8 to 15 change nothing.
- R5: Each set bit of dev_post sets that pending bit at the next clock edge.
- R6: Each set bit of dev_clear clears that pending bit at the next clock edge.
- R7: When a bit is posted in the same cycle as it is cleared or acknowledged, the post wins and the bit ends set.
- R8: Reading address 2 (primary status) returns the pending register, zero-extended to 64 bits.
- R9: A write to address 1 (cascaded mask) is stored inverted and reads back as written at address 1. It never changes irq_out.
- R10: Address 3 (cascaded status) always reads 0. A write to address 5 (cascaded acknowledge) changes no pending bit. Reads of addresses 4 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 64 | Combinational read data, zero-extended |
| dev_post | input | 8 | Device request vector; sets pending bits |
| dev_clear | input | 8 | Device clear vector; clears pending bits |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
A corrupted pending bit or enable bit shows in the status or mask readback as soon as that register is read. It also shows on irq_out in the cycle after the edge at which it went wrong, if the bit is both pending and enabled. The bench reads every register after each random operation, so a wrong state is reported within one operation. It also compares irq_out every cycle. Directed cases cover post against clear and acknowledge on the same bit, out-of-range acknowledge indices, and cascaded-port writes that must leave the host line and the pending bits unchanged.

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int LINES = 8,
  parameter int AW    = 3,
  parameter int RW    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [RW-1:0]    bus_rdata,
  input  logic [LINES-1:0] dev_post,
  input  logic [LINES-1:0] dev_clear,
  output logic             irq_out
);
  localparam logic [AW-1:0] A_MASK_PRI = AW'(0);
  localparam logic [AW-1:0] A_MASK_SEC = AW'(1);
  localparam logic [AW-1:0] A_STAT_PRI = AW'(2);

  logic [LINES-1:0] pend_q, en_pri_q, en_sec_q, ack_vec;

  wire wr_mask_pri = bus_we && (bus_addr == A_MASK_PRI);
  wire wr_mask_sec = bus_we && (bus_addr == A_MASK_SEC);
  wire wr_ack_pri  = bus_we && (bus_addr == AW'(4));

  always_comb
    for (int i = 0; i < LINES; i++)
      ack_vec[i] = wr_ack_pri && (bus_wdata[3:0] == 4'(i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      en_pri_q <= '0;
      en_sec_q <= '0;
    end else begin
      pend_q <= (pend_q & ~dev_clear & ~ack_vec) | dev_post;
      if (wr_mask_pri) en_pri_q <= ~bus_wdata[LINES-1:0];
      if (wr_mask_sec) en_sec_q <= ~bus_wdata[LINES-1:0];
    end
  end

  assign irq_out = |(pend_q & en_pri_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MASK_PRI: bus_rdata[LINES-1:0] = ~en_pri_q;
      A_MASK_SEC: bus_rdata[LINES-1:0] = ~en_sec_q;
      A_STAT_PRI: bus_rdata[LINES-1:0] = pend_q;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int LINES = 8,
  parameter int AW    = 3,
  parameter int RW    = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [RW-1:0]    bus_rdata,
  input logic [LINES-1:0] dev_post,
  input logic [LINES-1:0] dev_clear,
  input logic [LINES-1:0] pend,
  input logic [LINES-1:0] en,
  input logic             irq_out
);
  // R2
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(0)) |=> en == ~$past(bus_wdata[LINES-1:0]));

  // R5
  post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_post) |=> ((pend & $past(dev_post)) == $past(dev_post)));

  // R6
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dev_clear & ~dev_post)) |=> ((pend & $past(dev_clear & ~dev_post)) == '0));

  // R4
  ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(4) && bus_wdata[3:0] < 4'(LINES) && dev_post == '0)
      |=> pend[$past(bus_wdata[2:0])] == 1'b0);

  // R9
  sec_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(1) && dev_post == '0 && dev_clear == '0) |=> $stable(irq_out));

  // R10
  sec_stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(3)) |-> bus_rdata == '0);

  // R3
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (en != '0 && pend != '0));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.LINES(LINES), .AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_post(dev_post),
  .dev_clear(dev_clear), .pend(pend_q), .en(en_pri_q), .irq_out(irq_out)
);

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [7:0]  dev_post = '0;
  logic [7:0]  dev_clear = '0;
  logic        irq_out;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] m_pend = '0, m_mask_a = 8'hFF, m_mask_b = 8'hFF;

  irq_mask_ctrl u_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_post(dev_post),
    .dev_clear(dev_clear), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ack_bits(logic we, logic [2:0] a, logic [7:0] d);
    logic [7:0] v = '0;
    if (we && a == 3'd4 && d[3:0] < 4'd8) v[d[2:0]] = 1'b1;
    return v;
  endfunction

  function automatic logic [63:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return {56'd0, m_mask_a};
      3'd1: return {56'd0, m_mask_b};
      3'd2: return {56'd0, m_pend};
      default: return 64'd0;
    endcase
  endfunction

  task automatic step(logic we, logic [2:0] a, logic [7:0] d, logic [7:0] p, logic [7:0] c);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; dev_post = p; dev_clear = c;
    @(posedge clk);
    m_pend = (m_pend & ~c & ~ack_bits(we, a, d)) | p;
    if (we && a == 3'd0) m_mask_a = d;
    if (we && a == 3'd1) m_mask_b = d;
    @(negedge clk);
    bus_we = 1'b0; dev_post = '0; dev_clear = '0;
    check("R3 irq", {63'd0, irq_out}, {63'd0, |(m_pend & ~m_mask_a)});
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a);
      #1;
      check(req, bus_rdata, exp_read(3'(a)));
    end
  endtask

  initial begin
    logic [7:0] irq_before;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    read_all("R1 reset");
    check("R1 irq", {63'd0, irq_out}, 64'd0);

    // R5 post while masked, then R2 R3 enable
    step(1'b0, 3'd0, 8'h00, 8'h24, 8'h00);
    read_all("R5 post");
    step(1'b1, 3'd0, 8'hFB, 8'h00, 8'h00);
    read_all("R2 mask");
    check("R3 irq on enable", {63'd0, irq_out}, 64'd1);
    // R4 ack with upper bits set and out-of-range
    step(1'b1, 3'd4, 8'hF2, 8'h00, 8'h00);
    read_all("R4 ack upper bits");
    check("R3 irq after ack", {63'd0, irq_out}, 64'd0);
    step(1'b1, 3'd4, 8'h0D, 8'h00, 8'h00);
    read_all("R4 ack index 13");
    // R7 post beats clear and ack
    step(1'b1, 3'd4, 8'h05, 8'h20, 8'h20);
    read_all("R7 post priority");
    check("R7 pend bit5", {63'd0, m_pend[5]}, 64'd1);
    // R6 clear
    step(1'b0, 3'd0, 8'h00, 8'h00, 8'hFF);
    read_all("R6 clear");
    // R9 R10 cascaded ports
    step(1'b0, 3'd0, 8'h00, 8'h81, 8'h00);
    step(1'b1, 3'd0, 8'h7E, 8'h00, 8'h00);
    irq_before = {7'd0, irq_out};
    step(1'b1, 3'd1, 8'h00, 8'h00, 8'h00);
    check("R9 sec mask irq", {56'd0, 7'd0, irq_out}, {56'd0, irq_before});
    step(1'b1, 3'd5, 8'h00, 8'h00, 8'h00);
    read_all("R10 sec ack/status");
    // R8 random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      step(1'($urandom_range(0, 1)), a, 8'($urandom),
           ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00,
           ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00);
      read_all("R8 random readback");
    end
    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); @(negedge clk); rst_n = 1'b1;
    m_pend = '0; m_mask_a = 8'hFF; m_mask_b = 8'hFF;
    read_all("R1 re-reset");
    check("R1 irq re-reset", {63'd0, irq_out}, 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule